// File: doc/BRIEF.md
# Post-Update Pointer Unit with Limit Skip

This block carries out the data-move part of load and exchange operations that address memory through a pointer register and then step that pointer. It holds four 16-bit registers: the accumulator, two pointers (X and B) and a limit register (K). When an operation starts, the unit reads memory at the pointer's current value. An exchange also writes the old accumulator back to the same address. The accumulator takes the value read. The pointer then moves up or down by one for a byte access or by two for a word access.

When the conditional-skip variant is used with the B pointer, the stepped value of B is compared with K, and a one-cycle skip-next pulse tells the sequencer to drop the following instruction. The unit also performs decrement-and-skip-if-zero on any of its four registers. Memory is reached through a simple request/acknowledge port. A register write port lets the surrounding core load the registers, and all four registers are visible on outputs.

Top module: `ptr_walk_unit`

## Requirements
- R1: After a synchronous active-low reset, the accumulator, X, B and K are all zero, and done, skip_next and mem_req are low.
- R2: While the unit is idle, reg_wr loads reg_wdata into the register chosen by reg_sel (0 = accumulator, 1 = X, 2 = B, 3 = K), and the value is visible on the register outputs after that clock edge.
- R3: A load (op 0, or op 3 treated the same) reads memory at the pointer's value before the step and puts the result in the accumulator. A byte access (wide = 0) keeps only bits 7:0 of the read data and clears bits 15:8.
- R4: An exchange (op 1) first reads at the old pointer value, then writes the old accumulator to the same address, then puts the read value in the accumulator. A byte exchange writes with mem_wide low, with bits 15:8 of mem_wdata zero, and the accumulator receives the read byte zero-extended.
- R5: After the transfer, the selected pointer (ptr_sel 0 = X, 1 = B) changes by 1 for a byte access or by 2 for a word access. It goes up when dir_dn = 0 and down when dir_dn = 1, with 16-bit wrap-around.
- R6: An operation through X never asserts skip_next, even with skip_en = 1, and leaves B and K unchanged.
- R7: With ptr_sel = B, skip_en = 1 and dir_dn = 0, skip_next is asserted when the stepped B is greater than K as an unsigned 16-bit number. It is not asserted when they are equal.
- R8: With ptr_sel = B, skip_en = 1 and dir_dn = 1, skip_next is asserted when the stepped B is less than K as an unsigned number. It is not asserted when they are equal.
- R9: With skip_en = 0, no load or exchange asserts skip_next.
- R10: Decrement-skip-if-zero (op 2) subtracts one from the register chosen by reg_sel, with wrap-around. It makes no memory access. It raises done in the cycle after start, and raises skip_next with it exactly when the result is zero.
- R11: done is a single-cycle pulse per operation, and skip_next is high only in a cycle where done is high.
- R12: A start that arrives while an operation is in progress is ignored: it causes no second done and has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 load, 1 exchange, 2 decrement-skip-if-zero, 3 load |
| ptr_sel | input | 1 | Pointer used: 0 = X, 1 = B |
| dir_dn | input | 1 | Pointer step: 0 = up, 1 = down |
| wide | input | 1 | Access width: 1 = word, 0 = byte |
| skip_en | input | 1 | Conditional-skip variant (effective only with B) |
| reg_sel | input | 2 | Register for writes and decrement: 0 acc, 1 X, 2 B, 3 K |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_wide | output | 1 | Access width on the memory port |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| done | output | 1 | Operation complete pulse |
| skip_next | output | 1 | Skip the following instruction (pulse with done) |
| acc | output | 16 | Accumulator |
| x_ptr | output | 16 | X pointer |
| b_ptr | output | 16 | B pointer |
| k_lim | output | 16 | K limit register |

## Verification
The hardest conditions to reach are the edges of the limit comparison. The skip decision uses the value of B after the step, so the stimulus must place B one step away from K for both directions and both widths. The bench loads B and K through the write port so that the stepped B lands exactly on K, just past it, and across the 16-bit wrap. A second awkward case is a start that arrives while a memory read is waiting. To reach it, the bench raises start again in the cycle right after an operation begins, while the model memory still withholds its acknowledge.

// File: rtl/ptrw_pkg.sv
// Package: shared encodings for the post-update pointer unit.
// Assumes: 2-bit operation and register codes as listed in the brief.
package ptrw_pkg;
    typedef enum logic [1:0] {
        OP_LOAD     = 2'd0,
        OP_EXCH     = 2'd1,
        OP_DSZ      = 2'd2,
        OP_LOAD_ALT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RG_ACC = 2'd0,
        RG_X   = 2'd1,
        RG_B   = 2'd2,
        RG_K   = 2'd3
    } reg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } st_e;
endpackage

// File: rtl/ptrw_seq.sv
// Sequencer: captures an operation at start, drives the memory port
// (read, then write for exchange), and flags the single finish cycle.
// Assumes: the memory holds mem_rdata valid while it asserts mem_ack,
// and the register values do not change before the finish cycle.
module ptrw_seq
    import ptrw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic          ptr_sel_i,
    input  logic          dir_dn_i,
    input  logic          wide_i,
    input  logic          skip_en_i,
    input  logic [1:0]    reg_sel_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] b_i,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          fin_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic          mem_wide_o,
    output logic [DW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output op_e           l_op_o,
    output logic          l_ptr_b_o,
    output logic          l_dn_o,
    output logic          l_wide_o,
    output logic          l_skip_en_o,
    output reg_e          l_reg_o,
    output logic [DW-1:0] rdata_q_o
);
    localparam int BW = DW / 2;

    st_e state;

    // Operation state machine and capture of the operation fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            l_op_o      <= OP_LOAD;
            l_ptr_b_o   <= 1'b0;
            l_dn_o      <= 1'b0;
            l_wide_o    <= 1'b0;
            l_skip_en_o <= 1'b0;
            l_reg_o     <= RG_ACC;
            rdata_q_o   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    l_op_o      <= op_e'(op_i);
                    l_ptr_b_o   <= ptr_sel_i;
                    l_dn_o      <= dir_dn_i;
                    l_wide_o    <= wide_i;
                    l_skip_en_o <= skip_en_i;
                    l_reg_o     <= reg_e'(reg_sel_i);
                    state       <= (op_e'(op_i) == OP_DSZ) ? ST_FIN : ST_READ;
                end
                ST_READ: if (mem_ack_i) begin
                    rdata_q_o <= mem_rdata_i;
                    state     <= (l_op_o == OP_EXCH) ? ST_WRITE : ST_FIN;
                end
                ST_WRITE: if (mem_ack_i) state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Memory port decode from the current state
    always_comb begin
        busy_o      = (state != ST_IDLE);
        fin_o       = (state == ST_FIN);
        mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
        mem_we_o    = (state == ST_WRITE);
        mem_wide_o  = l_wide_o;
        mem_addr_o  = l_ptr_b_o ? b_i : x_i;
        mem_wdata_o = l_wide_o ? acc_i : {{(DW-BW){1'b0}}, acc_i[BW-1:0]};
    end

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);

    // R4
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> ($past(mem_req_o) && !$past(mem_we_o)));

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R12
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(l_op_o) && $stable(l_reg_o)));
endmodule

// File: rtl/ptrw_step.sv
// Step logic: works out the register update, the accumulator result and
// the skip decision for the finish cycle of an operation.
// Assumes: inputs hold the captured operation and the registers' pre-update values.
module ptrw_step
    import ptrw_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           l_op_i,
    input  logic          l_ptr_b_i,
    input  logic          l_dn_i,
    input  logic          l_wide_i,
    input  logic          l_skip_en_i,
    input  reg_e          l_reg_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] k_i,
    input  logic [DW-1:0] rdata_i,
    output reg_e          upd_sel_o,
    output logic [DW-1:0] upd_val_o,
    output logic          acc_upd_o,
    output logic [DW-1:0] acc_new_o,
    output logic          skip_o
);
    localparam int BW = DW / 2;
    localparam logic [DW-1:0] ONE = DW'(1);
    localparam logic [DW-1:0] TWO = DW'(2);

    logic [DW-1:0] old_ptr, step, new_ptr, dsz_src, dsz_res;

    // Pointer step and limit comparison on the stepped value
    always_comb begin
        old_ptr = l_ptr_b_i ? b_i : x_i;
        step    = l_wide_i ? TWO : ONE;
        new_ptr = l_dn_i ? (old_ptr - step) : (old_ptr + step);
        case (l_reg_i)
            RG_ACC:  dsz_src = acc_i;
            RG_X:    dsz_src = x_i;
            RG_B:    dsz_src = b_i;
            default: dsz_src = k_i;
        endcase
        dsz_res = dsz_src - ONE;
    end

    // Selection between decrement-skip and pointer-move results
    always_comb begin
        if (l_op_i == OP_DSZ) begin
            upd_sel_o = l_reg_i;
            upd_val_o = dsz_res;
            acc_upd_o = 1'b0;
            acc_new_o = acc_i;
            skip_o    = (dsz_res == '0);
        end else begin
            upd_sel_o = l_ptr_b_i ? RG_B : RG_X;
            upd_val_o = new_ptr;
            acc_upd_o = 1'b1;
            acc_new_o = l_wide_i ? rdata_i : {{(DW-BW){1'b0}}, rdata_i[BW-1:0]};
            skip_o    = l_ptr_b_i && l_skip_en_i &&
                        (l_dn_i ? (new_ptr < k_i) : (new_ptr > k_i));
        end
    end
endmodule

// File: rtl/ptrw_regs.sv
// Register file: accumulator, X, B and K with a core write port (idle only)
// and an update port used in the finish cycle.
// Assumes: the update port is only enabled while the write port is blocked.
module ptrw_regs
    import ptrw_pkg::*;
#(
    parameter int DW = 16,
    parameter int NREG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          upd_en_i,
    input  reg_e          upd_sel_i,
    input  logic [DW-1:0] upd_val_i,
    input  logic          acc_upd_i,
    input  logic [DW-1:0] acc_new_i,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] x_o,
    output logic [DW-1:0] b_o,
    output logic [DW-1:0] k_o
);
    logic [DW-1:0] rf [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            // One register: update port first, then core write, else hold
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rf[i] <= '0;
                else if (upd_en_i && (int'(upd_sel_i) == i))
                    rf[i] <= upd_val_i;
                else if (upd_en_i && acc_upd_i && (i == int'(RG_ACC)))
                    rf[i] <= acc_new_i;
                else if (wr_en_i && (int'(wr_sel_i) == i))
                    rf[i] <= wr_data_i;
            end
        end
    endgenerate

    assign acc_o = rf[RG_ACC];
    assign x_o   = rf[RG_X];
    assign b_o   = rf[RG_B];
    assign k_o   = rf[RG_K];

    // R6
    x_move_keeps_bk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && acc_upd_i && upd_sel_i == RG_X) |=> ($stable(b_o) && $stable(k_o)));
endmodule

// File: rtl/ptr_walk_unit.sv
// Top: post-update pointer unit for load/exchange with limit skip and
// decrement-skip-if-zero. Wires sequencer, step logic and register file.
// Assumes: one operation at a time; memory answers each request with mem_ack.
module ptr_walk_unit
    import ptrw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic          ptr_sel,
    input  logic          dir_dn,
    input  logic          wide,
    input  logic          skip_en,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_wide,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          done,
    output logic          skip_next,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] x_ptr,
    output logic [DW-1:0] b_ptr,
    output logic [DW-1:0] k_lim
);
    logic          busy, fin, l_ptr_b, l_dn, l_wide, l_skip_en;
    logic          acc_upd, skip_c;
    op_e           l_op;
    reg_e          l_reg, upd_sel;
    logic [DW-1:0] rdata_q, upd_val, acc_new;

    ptrw_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .ptr_sel_i(ptr_sel), .dir_dn_i(dir_dn), .wide_i(wide),
        .skip_en_i(skip_en), .reg_sel_i(reg_sel), .acc_i(acc),
        .x_i(x_ptr), .b_i(b_ptr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .fin_o(fin), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_wide_o(mem_wide), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .l_op_o(l_op), .l_ptr_b_o(l_ptr_b), .l_dn_o(l_dn), .l_wide_o(l_wide),
        .l_skip_en_o(l_skip_en), .l_reg_o(l_reg), .rdata_q_o(rdata_q)
    );

    ptrw_step #(.DW(DW)) u_step (
        .l_op_i(l_op), .l_ptr_b_i(l_ptr_b), .l_dn_i(l_dn), .l_wide_i(l_wide),
        .l_skip_en_i(l_skip_en), .l_reg_i(l_reg), .acc_i(acc), .x_i(x_ptr),
        .b_i(b_ptr), .k_i(k_lim), .rdata_i(rdata_q), .upd_sel_o(upd_sel),
        .upd_val_o(upd_val), .acc_upd_o(acc_upd), .acc_new_o(acc_new),
        .skip_o(skip_c)
    );

    ptrw_regs #(.DW(DW), .NREG(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr && !busy), .wr_sel_i(reg_sel),
        .wr_data_i(reg_wdata), .upd_en_i(fin), .upd_sel_i(upd_sel),
        .upd_val_i(upd_val), .acc_upd_i(acc_upd), .acc_new_i(acc_new),
        .acc_o(acc), .x_o(x_ptr), .b_o(b_ptr), .k_o(k_lim)
    );

    // Completion strobes
    assign done      = fin;
    assign skip_next = fin && skip_c;

    // R11
    skip_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_next |-> done);

    // R10
    dsz_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 2'd2) |=> (done && !mem_req));
endmodule

// File: tb/tb_ptr_walk_unit.sv
`timescale 1ns/1ps
module tb_ptr_walk_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        ptr_sel = 1'b0, dir_dn = 1'b0, wide = 1'b0, skip_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic        mem_req, mem_we, mem_wide, done, skip_next;
    logic [15:0] mem_addr, mem_wdata, acc, x_ptr, b_ptr, k_lim;
    logic [15:0] mem_rdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem [0:255];

    int n_chk = 0;
    int n_fail = 0;
    logic got_skip;
    int   wait_cyc;

    always #2.5 clk = ~clk;

    ptr_walk_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ptr_sel(ptr_sel),
        .dir_dn(dir_dn), .wide(wide), .skip_en(skip_en), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done), .skip_next(skip_next),
        .acc(acc), .x_ptr(x_ptr), .b_ptr(b_ptr), .k_lim(k_lim)
    );

    // Model memory: acknowledge one cycle after a request, one word per address
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_we && mem_ack) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Issue one operation, optionally a second start while busy, wait for done
    task automatic run_op(input logic [1:0] o, input logic pb, input logic dn,
                          input logic wd, input logic se, input logic [1:0] rs,
                          input logic poke_busy);
        @(negedge clk);
        op = o; ptr_sel = pb; dir_dn = dn; wide = wd; skip_en = se; reg_sel = rs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc = 0;
        if (poke_busy && !done) begin
            op = 2'd2; reg_sel = 2'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_cyc = 1;
        end
        while (!done && wait_cyc < 40) begin
            @(negedge clk);
            wait_cyc++;
        end
        got_skip = skip_next;
        chk("R11 done seen", {15'h0, done}, 16'h1);
        @(negedge clk);
        chk("R11 done single pulse", {15'h0, done}, 16'h0);
        chk("R11 skip with done only", {15'h0, skip_next}, 16'h0);
    endtask

    task automatic t_reset;
        chk("R1 acc", acc, 16'h0);
        chk("R1 x", x_ptr, 16'h0);
        chk("R1 b", b_ptr, 16'h0);
        chk("R1 k", k_lim, 16'h0);
        chk("R1 done/skip/req", {13'h0, done, skip_next, mem_req}, 16'h0);
    endtask

    task automatic t_regwrite;
        wr_reg(2'd0, 16'h1111); wr_reg(2'd1, 16'h2222);
        wr_reg(2'd2, 16'h3333); wr_reg(2'd3, 16'h4444);
        @(negedge clk);
        chk("R2 acc", acc, 16'h1111);
        chk("R2 x", x_ptr, 16'h2222);
        chk("R2 b", b_ptr, 16'h3333);
        chk("R2 k", k_lim, 16'h4444);
    endtask

    task automatic t_load_x;
        mem[8'h10] = 16'hBEEF;
        wr_reg(2'd1, 16'h0010); wr_reg(2'd2, 16'h0070); wr_reg(2'd3, 16'h0000);
        run_op(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0);
        chk("R3 load word acc", acc, 16'hBEEF);
        chk("R5 x word up", x_ptr, 16'h0012);
        chk("R6 x no skip", {15'h0, got_skip}, 16'h0);
        chk("R6 b unchanged", b_ptr, 16'h0070);
        chk("R6 k unchanged", k_lim, 16'h0000);
        mem[8'h20] = 16'h12AB;
        wr_reg(2'd1, 16'h0020);
        run_op(2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
        chk("R3 load byte zero-extend", acc, 16'h00AB);
        chk("R5 x byte down", x_ptr, 16'h001F);
    endtask

    task automatic t_exch;
        mem[8'h30] = 16'h1234;
        wr_reg(2'd0, 16'h5A5A); wr_reg(2'd2, 16'h0030); wr_reg(2'd3, 16'h0030);
        run_op(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        chk("R4 exch word acc", acc, 16'h1234);
        chk("R4 exch word mem", mem[8'h30], 16'h5A5A);
        chk("R5 b word up", b_ptr, 16'h0032);
        chk("R9 no skip without enable", {15'h0, got_skip}, 16'h0);
        mem[8'h40] = 16'h7788;
        wr_reg(2'd0, 16'hCAFE); wr_reg(2'd1, 16'h0040);
        run_op(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        chk("R4 exch byte mem", mem[8'h40], 16'h00FE);
        chk("R4 exch byte acc", acc, 16'h0088);
        chk("R5 x byte up", x_ptr, 16'h0041);
    endtask

    task automatic t_skip_up;
        wr_reg(2'd2, 16'h0050); wr_reg(2'd3, 16'h0051);
        run_op(2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0);
        chk("R7 skip b>k", {15'h0, got_skip}, 16'h1);
        chk("R7 b stepped", b_ptr, 16'h0052);
        wr_reg(2'd2, 16'h0050); wr_reg(2'd3, 16'h0052);
        run_op(2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0);
        chk("R7 no skip b==k", {15'h0, got_skip}, 16'h0);
        wr_reg(2'd2, 16'hFFFF); wr_reg(2'd3, 16'h8000);
        run_op(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
        chk("R5 b wraps", b_ptr, 16'h0000);
        chk("R7 unsigned after wrap", {15'h0, got_skip}, 16'h0);
    endtask

    task automatic t_skip_dn;
        wr_reg(2'd2, 16'h0060); wr_reg(2'd3, 16'h005F);
        run_op(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0);
        chk("R8 skip b<k", {15'h0, got_skip}, 16'h1);
        chk("R8 b stepped", b_ptr, 16'h005E);
        wr_reg(2'd2, 16'h0060); wr_reg(2'd3, 16'h005E);
        run_op(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0);
        chk("R8 no skip b==k", {15'h0, got_skip}, 16'h0);
    endtask

    task automatic t_dsz;
        wr_reg(2'd3, 16'h0001);
        run_op(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0);
        chk("R10 done next cycle", wait_cyc[15:0], 16'h0);
        chk("R10 k to zero skips", {15'h0, got_skip}, 16'h1);
        chk("R10 k value", k_lim, 16'h0000);
        wr_reg(2'd1, 16'h0005);
        run_op(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
        chk("R10 x decremented", x_ptr, 16'h0004);
        chk("R10 nonzero no skip", {15'h0, got_skip}, 16'h0);
        wr_reg(2'd0, 16'h0000);
        run_op(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        chk("R10 acc wraps", acc, 16'hFFFF);
        chk("R10 wrap no skip", {15'h0, got_skip}, 16'h0);
    endtask

    task automatic t_busy;
        mem[8'h80] = 16'h0F0F;
        wr_reg(2'd1, 16'h0080); wr_reg(2'd3, 16'h0009);
        run_op(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1);
        chk("R12 first op result", acc, 16'h0F0F);
        chk("R12 k untouched", k_lim, 16'h0009);
        repeat (3) @(negedge clk);
        chk("R12 no second done", {15'h0, done}, 16'h0);
        chk("R12 k still untouched", k_lim, 16'h0009);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regwrite();
        t_load_x();
        t_exch();
        t_skip_up();
        t_skip_dn();
        t_dsz();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule